// File: doc/BRIEF.md
# Register-Driven Memory Download Controller

This block lets a host fill on-chip memories by writing bytes into two byte-wide registers. The host first writes an eight-byte header. The header names the target memory, the first address, the number of payload bytes and the checksum it expects. The host then streams the payload bytes through a data register, followed by a two-byte checksum trailer. The controller writes each payload byte to the selected memory at consecutive addresses and keeps a 16-bit running sum. It reports the outcome through one error bit per memory, a protocol-error bit, a program-memory lock flag, a busy flag and a session-ended flag.

A memory's error bit is raised as soon as a load of that memory is started. It drops only when the load finishes with a checksum that matches. A partial or corrupted transfer therefore stays on record, even while later loads of other memories succeed. After a successful program-memory load, that memory cannot be loaded again until reset. A header with a zero byte count closes the download session.

Top module: `mem_dl_ctrl`

## Requirements
- R1: A register write with `reg_sel`=0 feeds the header register one byte at a time. The bytes are taken in this order: byte 0 is the memory id (0 = program memory, 1 = data memory, any other value is invalid); bytes 1–2 are the start address, MSB first; bytes 3–4 are the byte count, MSB first; bytes 5–6 are the expected checksum, MSB first; byte 7 is ignored. A header takes effect only when its eighth byte is written.
- R2: While a load is active, each write with `reg_sel`=1 carries one payload byte. Each payload byte appears on the memory port one cycle after its strobe, with `mem_we`=1 for that one cycle. `mem_sel` equals the header's memory id and `mem_wdata` equals the byte. `mem_addr` is the start address for the first byte and then increments by one per byte, modulo 2^ADDR_W.
- R3: A completed header with a nonzero count that starts a load sets the error bit of its memory one cycle after the eighth byte. Error bit 0 belongs to program memory and bit 1 to data memory.
- R4: After the counted payload, the next two data-register bytes form the checksum trailer, MSB first. The error bit is cleared one cycle after the second trailer byte only if two conditions both hold: the trailer equals the modulo-65536 sum of the payload bytes, and the header checksum equals that same sum. Otherwise the error bit stays set.
- R5: The error bits of different memories are independent. A load of one memory never changes another memory's bit.
- R6: A header-register write during an active load abandons that load. No further memory writes come from it, and its error bit stays set.
- R7: After a successful program-memory load, `status_prog_locked` is 1. From then on, a header that targets program memory sets the program error bit, starts no load and causes no memory writes, until reset.
- R8: A completed header whose count is zero raises `status_session_end` one cycle later. After that, every register write is ignored until reset: there are no memory writes and no status changes.
- R9: A data-register write when no load is active causes no memory write and sets the sticky `status_proto_err`.
- R10: A completed header with a nonzero count and an invalid memory id sets `status_proto_err`, starts no load and leaves the memory error bits unchanged.
- R11: After reset, every status output and `mem_we` are 0.
- R12: `status_busy` is 1 from the cycle after a load-starting header completes until the cycle after the second trailer byte, or until the load is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe, one byte per cycle |
| reg_sel | input | 1 | 0 = header register, 1 = data register |
| reg_wdata | input | 8 | Byte being written |
| mem_we | output | 1 | Memory write enable |
| mem_sel | output | MEM_SEL_W | Target memory (0 program, 1 data) |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| status_mem_err | output | NUM_MEM | Per-memory load error bits |
| status_proto_err | output | 1 | Sticky protocol-error bit |
| status_prog_locked | output | 1 | Program memory is write-locked |
| status_busy | output | 1 | A load is in progress |
| status_session_end | output | 1 | A termination header has been received |

## Verification
Every result of this block is registered once: memory writes, error-bit changes, the busy flag, the lock flag and the session-end flag. Each therefore changes at the rising edge that captures the strobe causing it, and is visible for the cycle that follows. The bench drives each register write on a falling edge and holds it across one rising edge. It then samples all outputs at the next falling edge, exactly one cycle after the capture. Each payload byte's memory write is checked at the sample point right after that byte. Tests that expect no effect check `mem_we` and the status bits at the same point after every ignored byte.

// File: rtl/mdl_pkg.sv
package mdl_pkg;

  localparam int HDR_BYTES = 8;
  localparam int SUM_W     = 16;

  // byte positions inside the header register
  localparam int HB_ID   = 0;
  localparam int HB_ADDR = 1;
  localparam int HB_CNT  = 3;
  localparam int HB_SUM  = 5;

  localparam logic SEL_HDR  = 1'b0;
  localparam logic SEL_DATA = 1'b1;

  localparam int PROG_ID = 0;

  typedef struct packed {
    logic [7:0]  mem_id;
    logic [15:0] start;
    logic [15:0] count;
    logic [15:0] csum;
  } hdr_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAYLOAD,
    ST_SUM_HI,
    ST_SUM_LO,
    ST_ENDED
  } seq_state_e;

endpackage

// File: rtl/mdl_hdr_asm.sv
module mdl_hdr_asm
  import mdl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] byte_i,
  output logic       done,
  output hdr_t       hdr_o
);

  localparam int IDX_W = $clog2(HDR_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_BYTES - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]       bytes [HDR_BYTES-1];

  always_comb begin
    if (idx_q == LAST_IDX) idx_d = '0;
    else                   idx_d = idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (wr_en) idx_q <= idx_d;
  end

  // one capture register per stored header byte; the last byte is not kept
  for (genvar k = 0; k < HDR_BYTES - 1; k++) begin : g_byte
    logic       cap;
    logic [7:0] b_q;
    assign cap = wr_en && (idx_q == IDX_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   b_q <= '0;
      else if (cap) b_q <= byte_i;
    end
    assign bytes[k] = b_q;
  end

  assign done = wr_en && (idx_q == LAST_IDX);

  assign hdr_o.mem_id = bytes[HB_ID];
  assign hdr_o.start  = {bytes[HB_ADDR], bytes[HB_ADDR+1]};
  assign hdr_o.count  = {bytes[HB_CNT],  bytes[HB_CNT+1]};
  assign hdr_o.csum   = {bytes[HB_SUM],  bytes[HB_SUM+1]};

  p_idx_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx_q == LAST_IDX) |=> (idx_q == '0));

  p_idx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(idx_q));

endmodule

// File: rtl/mdl_csum.sv
module mdl_csum #(
  parameter int SUM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add,
  input  logic [7:0]       byte_i,
  output logic [SUM_W-1:0] acc_o
);

  logic [SUM_W-1:0] acc_q, acc_d;

  always_comb begin
    if (clr) acc_d = '0;
    else     acc_d = acc_q + SUM_W'(byte_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc_q <= '0;
    else if (clr || add) acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  p_sum_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_o == '0));

  p_sum_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !add) |=> $stable(acc_o));

endmodule

// File: rtl/mdl_load_seq.sv
module mdl_load_seq
  import mdl_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NUM_MEM = 2,
  localparam int ID_W   = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hdr_wr,
  input  logic               hdr_done,
  input  hdr_t               hdr_i,
  input  logic               data_wr,
  input  logic [7:0]         data_i,
  input  logic [SUM_W-1:0]   sum_i,
  output logic               sum_clr,
  output logic               sum_add,
  output logic               mem_we,
  output logic [ID_W-1:0]    mem_sel,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [7:0]         mem_wdata,
  output logic [NUM_MEM-1:0] err,
  output logic               proto_err,
  output logic               locked,
  output logic               busy,
  output logic               ended
);

  localparam logic [ID_W-1:0] PROG_SEL = ID_W'(PROG_ID);

  seq_state_e         state_q, state_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [15:0]        remain_q, remain_d;
  logic [ID_W-1:0]    cur_q, cur_d;
  logic [SUM_W-1:0]   exp_q, exp_d;
  logic [7:0]         hi_q, hi_d;
  logic               proto_q, proto_d;
  logic               locked_q, locked_d;
  logic               we_q, we_d;
  logic [ID_W-1:0]    sel_q, sel_d;
  logic [ADDR_W-1:0]  waddr_q, waddr_d;
  logic [7:0]         wdata_q, wdata_d;
  logic [NUM_MEM-1:0] err_set, err_clr;

  logic            id_ok, id_prog, hdr_eval, start_fire, trailer_ok;
  logic [ID_W-1:0] id_idx;
  logic            unused_hdr_bits;

  assign id_idx     = hdr_i.mem_id[ID_W-1:0];
  assign id_ok      = hdr_i.mem_id < 8'(NUM_MEM);
  assign id_prog    = hdr_i.mem_id == 8'(PROG_ID);
  assign hdr_eval   = hdr_wr && hdr_done && (state_q != ST_ENDED) && (hdr_i.count != '0);
  assign start_fire = hdr_eval && id_ok && !(id_prog && locked_q);
  assign trailer_ok = ({hi_q, data_i} == sum_i) && (sum_i == exp_q);
  assign unused_hdr_bits = ^{hdr_i.start, hdr_i.mem_id};

  // next-state process
  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    remain_d = remain_q;
    cur_d    = cur_q;
    exp_d    = exp_q;
    hi_d     = hi_q;
    proto_d  = proto_q;
    locked_d = locked_q;
    we_d     = 1'b0;
    sel_d    = sel_q;
    waddr_d  = waddr_q;
    wdata_d  = wdata_q;
    sum_clr  = 1'b0;
    sum_add  = 1'b0;
    err_set  = '0;
    err_clr  = '0;
    if (state_q != ST_ENDED) begin
      if (hdr_wr) begin
        state_d = ST_IDLE;
        if (hdr_done) begin
          if (hdr_i.count == '0) begin
            state_d = ST_ENDED;
          end else if (!id_ok) begin
            proto_d = 1'b1;
          end else if (id_prog && locked_q) begin
            err_set[PROG_ID] = 1'b1;
          end else begin
            err_set[id_idx] = 1'b1;
            state_d  = ST_PAYLOAD;
            addr_d   = hdr_i.start[ADDR_W-1:0];
            remain_d = hdr_i.count;
            cur_d    = id_idx;
            exp_d    = hdr_i.csum;
            sum_clr  = 1'b1;
          end
        end
      end else if (data_wr) begin
        unique case (state_q)
          ST_PAYLOAD: begin
            we_d     = 1'b1;
            sel_d    = cur_q;
            waddr_d  = addr_q;
            wdata_d  = data_i;
            addr_d   = addr_q + ADDR_W'(1);
            remain_d = remain_q - 16'd1;
            sum_add  = 1'b1;
            if (remain_q == 16'd1) state_d = ST_SUM_HI;
          end
          ST_SUM_HI: begin
            hi_d    = data_i;
            state_d = ST_SUM_LO;
          end
          ST_SUM_LO: begin
            if (trailer_ok) begin
              err_clr[cur_q] = 1'b1;
              if (cur_q == PROG_SEL) locked_d = 1'b1;
            end
            state_d = ST_IDLE;
          end
          default: proto_d = 1'b1;
        endcase
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      remain_q <= '0;
      cur_q    <= '0;
      exp_q    <= '0;
      hi_q     <= '0;
      proto_q  <= 1'b0;
      locked_q <= 1'b0;
      we_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      addr_q   <= addr_d;
      remain_q <= remain_d;
      cur_q    <= cur_d;
      exp_q    <= exp_d;
      hi_q     <= hi_d;
      proto_q  <= proto_d;
      locked_q <= locked_d;
      we_q     <= we_d;
    end
  end

  // memory port datapath, loaded only when a write is issued
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else if (we_d) begin
      sel_q   <= sel_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
    end
  end

  // one error flag per memory
  for (genvar m = 0; m < NUM_MEM; m++) begin : g_err
    logic e_q, e_d;
    always_comb begin
      if (err_set[m])      e_d = 1'b1;
      else if (err_clr[m]) e_d = 1'b0;
      else                 e_d = e_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      e_q <= 1'b0;
      else if (err_set[m] || err_clr[m]) e_q <= e_d;
    end
    assign err[m] = e_q;
  end

  assign mem_we    = we_q;
  assign mem_sel   = sel_q;
  assign mem_addr  = waddr_q;
  assign mem_wdata = wdata_q;
  assign proto_err = proto_q;
  assign locked    = locked_q;
  assign busy      = (state_q == ST_PAYLOAD) || (state_q == ST_SUM_HI) || (state_q == ST_SUM_LO);
  assign ended     = (state_q == ST_ENDED);

  p_err_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_fire |=> err[$past(id_idx)]);

  p_write_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !hdr_wr && state_q == ST_PAYLOAD) |=> mem_we);

  p_we_from_payload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(state_q) == ST_PAYLOAD));

  p_locked_no_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !(mem_we && mem_sel == PROG_SEL));

  p_ended_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ended |=> (ended && $stable(err) && $stable(proto_err) && !mem_we));

  p_stray_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && state_q == ST_IDLE) |=> proto_err);

  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_wr && busy) |=> !mem_we);

endmodule

// File: rtl/mem_dl_ctrl.sv
module mem_dl_ctrl
  import mdl_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_MEM    = 2,
  localparam int MEM_SEL_W = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [7:0]           reg_wdata,
  output logic                 mem_we,
  output logic [MEM_SEL_W-1:0] mem_sel,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [7:0]           mem_wdata,
  output logic [NUM_MEM-1:0]   status_mem_err,
  output logic                 status_proto_err,
  output logic                 status_prog_locked,
  output logic                 status_busy,
  output logic                 status_session_end
);

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic             hdr_en, data_en, hdr_done;
  hdr_t             hdr;
  logic             sum_clr, sum_add;
  logic [SUM_W-1:0] sum;
  logic             ended;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign hdr_en  = reg_wr && (reg_sel == SEL_HDR)  && !ended;
  assign data_en = reg_wr && (reg_sel == SEL_DATA) && !ended;

  mdl_hdr_asm u_hdr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (hdr_en),
    .byte_i (reg_wdata),
    .done   (hdr_done),
    .hdr_o  (hdr)
  );

  mdl_csum #(.SUM_W(SUM_W)) u_sum (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr    (sum_clr),
    .add    (sum_add),
    .byte_i (reg_wdata),
    .acc_o  (sum)
  );

  mdl_load_seq #(.ADDR_W(ADDR_W), .NUM_MEM(NUM_MEM)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .hdr_wr    (hdr_en),
    .hdr_done  (hdr_done),
    .hdr_i     (hdr),
    .data_wr   (data_en),
    .data_i    (reg_wdata),
    .sum_i     (sum),
    .sum_clr   (sum_clr),
    .sum_add   (sum_add),
    .mem_we    (mem_we),
    .mem_sel   (mem_sel),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .err       (status_mem_err),
    .proto_err (status_proto_err),
    .locked    (status_prog_locked),
    .busy      (status_busy),
    .ended     (ended)
  );

  assign status_session_end = ended;

  p_reset_quiet_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (!mem_we && status_mem_err == '0 && !status_busy));

endmodule

// File: tb/mem_dl_ctrl_bench.sv
module mem_dl_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_sel;
  logic [7:0]  reg_wdata;
  logic        mem_we;
  logic [0:0]  mem_sel;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [1:0]  status_mem_err;
  logic        status_proto_err;
  logic        status_prog_locked;
  logic        status_busy;
  logic        status_session_end;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  mem_dl_ctrl u_mem_dl_ctrl (
    .clk                (clk),
    .rst_n              (rst_n),
    .reg_wr             (reg_wr),
    .reg_sel            (reg_sel),
    .reg_wdata          (reg_wdata),
    .mem_we             (mem_we),
    .mem_sel            (mem_sel),
    .mem_addr           (mem_addr),
    .mem_wdata          (mem_wdata),
    .status_mem_err     (status_mem_err),
    .status_proto_err   (status_proto_err),
    .status_prog_locked (status_prog_locked),
    .status_busy        (status_busy),
    .status_session_end (status_session_end)
  );

  // mode: 0 good, 1 bad trailer, 2 bad header checksum, 3 all-0xFF payload (good)
  typedef struct packed {
    logic [7:0]  id;
    logic [15:0] addr;
    logic [15:0] cnt;
    logic [7:0]  seed;
    logic [1:0]  mode;
    logic        exp_p;
    logic        exp_d;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'd1, 16'h0010, 16'd5,   8'h11, 2'd0, 1'b0, 1'b0},
    '{8'd1, 16'h0100, 16'd9,   8'hF0, 2'd1, 1'b0, 1'b1},
    '{8'd0, 16'h0020, 16'd4,   8'h80, 2'd2, 1'b1, 1'b1},
    '{8'd1, 16'h0FFC, 16'd16,  8'h05, 2'd0, 1'b1, 1'b0},
    '{8'd1, 16'h0400, 16'd258, 8'h00, 2'd3, 1'b1, 1'b0},
    '{8'd0, 16'h0000, 16'd12,  8'h33, 2'd0, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] b);
    reg_wr    = 1'b1;
    reg_sel   = sel;
    reg_wdata = b;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic do_reset();
    reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic hdr_first7(input logic [7:0] id, input logic [15:0] a,
                            input logic [15:0] c, input logic [15:0] s);
    wr(1'b0, id);
    wr(1'b0, a[15:8]); wr(1'b0, a[7:0]);
    wr(1'b0, c[15:8]); wr(1'b0, c[7:0]);
    wr(1'b0, s[15:8]); wr(1'b0, s[7:0]);
  endtask

  task automatic send_hdr(input logic [7:0] id, input logic [15:0] a,
                          input logic [15:0] c, input logic [15:0] s);
    hdr_first7(id, a, c, s);
    wr(1'b0, 8'h00);
  endtask

  function automatic logic [31:0] status_word();
    return {26'd0, status_mem_err, status_proto_err, status_prog_locked,
            status_busy, status_session_end};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();

    // R11: reset state
    check("R11 status", status_word(), 32'd0);
    check("R11 mem_we", {31'd0, mem_we}, 32'd1 - 32'd1);

    // R9: stray data byte with no load
    wr(1'b1, 8'hAA);
    check("R9 no write", {31'd0, mem_we}, 32'd0);
    check("R9 proto", {31'd0, status_proto_err}, 32'd1);

    // R10: invalid memory id
    do_reset();
    send_hdr(8'd5, 16'h0000, 16'd4, 16'h0000);
    check("R10 proto", {31'd0, status_proto_err}, 32'd1);
    check("R10 errs", {30'd0, status_mem_err}, 32'd0);
    check("R10 busy", {31'd0, status_busy}, 32'd0);

    do_reset();

    // table-driven loads: R1 R2 R3 R4 R5 R12
    for (int v = 0; v < NV; v++) begin
      logic [7:0]  pay [260];
      logic [15:0] sum;
      logic [15:0] hsum;
      logic [15:0] tsum;
      sum = '0;
      for (int i = 0; i < int'(VECS[v].cnt); i++) begin
        pay[i] = (VECS[v].mode == 2'd3) ? 8'hFF : VECS[v].seed + 8'(i * 3);
        sum = sum + 16'(pay[i]);
      end
      hsum = (VECS[v].mode == 2'd2) ? (sum ^ 16'h0101) : sum;
      tsum = (VECS[v].mode == 2'd1) ? (sum + 16'd1) : sum;

      hdr_first7(VECS[v].id, VECS[v].addr, VECS[v].cnt, hsum);
      check("R1 seven bytes no start", {31'd0, status_busy}, 32'd0);
      wr(1'b0, 8'h5A);
      check("R12 busy after header", {31'd0, status_busy}, 32'd1);
      check("R3 err set", {31'd0, status_mem_err[VECS[v].id[0]]}, 32'd1);

      for (int i = 0; i < int'(VECS[v].cnt); i++) begin
        logic [11:0] ea;
        ea = VECS[v].addr[11:0] + 12'(i);
        wr(1'b1, pay[i]);
        check("R2 mem write", {11'd0, mem_we, mem_sel, ea, mem_wdata},
              {11'd0, 1'b1, VECS[v].id[0], ea, pay[i]});
        if (mem_addr !== ea) check("R2 mem addr", {20'd0, mem_addr}, {20'd0, ea});
      end

      wr(1'b1, tsum[15:8]);
      check("R4 no write on trailer", {31'd0, mem_we}, 32'd0);
      wr(1'b1, tsum[7:0]);
      check("R12 busy after trailer", {31'd0, status_busy}, 32'd0);
      check("R4 R5 error bits", {30'd0, status_mem_err},
            {30'd0, VECS[v].exp_d, VECS[v].exp_p});
    end

    check("R7 locked", {31'd0, status_prog_locked}, 32'd1);
    check("R9 proto clean", {31'd0, status_proto_err}, 32'd0);
    check("R8 not ended", {31'd0, status_session_end}, 32'd0);

    // R7: blocked reload of program memory
    send_hdr(8'd0, 16'h0000, 16'd3, 16'h0000);
    check("R7 prog err set", {31'd0, status_mem_err[0]}, 32'd1);
    check("R7 no load", {31'd0, status_busy}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      wr(1'b1, 8'h00);
      check("R7 no prog write", {31'd0, mem_we}, 32'd0);
    end
    check("R9 proto after stray", {31'd0, status_proto_err}, 32'd1);

    // R6: abort by header write
    send_hdr(8'd1, 16'h0300, 16'd6, 16'h0000);
    check("R3 data err set", {31'd0, status_mem_err[1]}, 32'd1);
    wr(1'b1, 8'h10);
    wr(1'b1, 8'h20);
    check("R2 before abort", {31'd0, mem_we}, 32'd1);
    wr(1'b0, 8'h01);
    check("R6 busy dropped", {31'd0, status_busy}, 32'd0);
    wr(1'b1, 8'h30);
    check("R6 no write after abort", {31'd0, mem_we}, 32'd0);
    check("R6 err kept", {31'd0, status_mem_err[1]}, 32'd1);

    // R8: rest of a zero-count header (byte 0 already written above)
    for (int i = 0; i < 7; i++) wr(1'b0, 8'h00);
    check("R8 session end", {31'd0, status_session_end}, 32'd1);
    begin
      logic [31:0] snap;
      snap = status_word();
      send_hdr(8'd1, 16'h0000, 16'd2, 16'h0002);
      check("R8 header ignored", status_word(), snap);
      wr(1'b1, 8'h01);
      check("R8 data ignored", {31'd0, mem_we}, 32'd0);
      wr(1'b1, 8'h01);
      check("R8 status frozen", status_word(), snap);
    end

    // R11: reset clears lock and session state
    do_reset();
    check("R11 after second reset", status_word(), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule